// File: doc/BRIEF.md
# UART receiver with overrun control

This block recovers 8N1 asynchronous serial frames (one start bit, eight data bits sent least significant bit first, one stop bit, no parity) from a single RX line. An internal divider produces an oversampling tick every `CLK_DIV` clocks, which gives sixteen ticks per bit. The line passes through a synchronizer. A four-state machine then finds the start bit, checks it, collects the data bits and samples the stop bit. Each finished byte goes to one holding register, and a data-valid flag marks it. The reader empties the register with a one-cycle read strobe.

Three configuration inputs set how the block behaves. The first picks the data-bit decision: a majority vote over samples 7, 8 and 9 of the bit, or sample 8 alone. The second turns overrun detection off, so that a new byte overwrites an unread one. The third enables an active-low request-to-send output, which follows whether the holding register is free. The block copies these three inputs only while its enable input is low. Sticky flags report noise, overrun and framing errors. A separate clear strobe resets all three flags.

State machine: `ST_IDLE` (line idle, watching for a low sample), `ST_START` (start bit being checked), `ST_DATA` (eight data bits shifted in), `ST_STOP` (stop bit sampled). Transitions: *start_seen* (ST_IDLE to ST_START, low sample on a tick); *false_start* (ST_START to ST_IDLE, start-bit majority high at sample 9); *start_ok* (ST_START to ST_DATA, at sample 15); *last_bit* (ST_DATA to ST_STOP, at sample 15 of data bit 7); *frame_end* (ST_STOP to ST_IDLE, at sample 9, when the byte is delivered); *disable* (any state to ST_IDLE while enable is low).

Top module: `uart_rx_ovr`

## Requirements
- R1: While enabled, the block takes one oversampling tick every CLK_DIV clocks and counts sixteen ticks per bit. It decodes 8N1 frames least significant bit first and places each byte on `rdata` with `rvalid` set.
- R2: A start bit counts only if the majority of its samples 7, 8 and 9 is low, in either sampling mode. Otherwise the frame is dropped and the outputs do not change.
- R3: In three-sample mode (`cfg_one_smp`=0), each data bit is the majority of samples 7, 8 and 9. `noise_flag` is set when the three samples of the start, any data or the stop bit of a frame disagree.
- R4: In single-sample mode (`cfg_one_smp`=1), each data bit is sample 8 alone, and `noise_flag` is never set.
- R5: `rd_stb` clears `rvalid` on the next clock. A byte that completes in the same cycle as a read is stored and does not cause an overrun.
- R6: With overrun detection on (`cfg_ovr_off`=0), a byte that completes while `rvalid` is set raises `ovr_flag`. The older byte stays in `rdata` and the new one is discarded.
- R7: With overrun detection off (`cfg_ovr_off`=1), such a byte overwrites `rdata` and `ovr_flag` stays clear.
- R8: A stop bit whose sample majority is 0 sets `frm_flag`, and the byte is still delivered.
- R9: `flag_clr` clears `ovr_flag`, `noise_flag` and `frm_flag`. A flag set in the same cycle takes priority.
- R10: `rts_n` is 0 exactly when request-to-send is enabled and `rvalid` is 0. Otherwise it is 1.
- R11: The three configuration inputs are copied only on clocks where `en` is 0. Changes made while `en` is 1 have no effect.
- R12: After reset, `rvalid` and all flags are 0, `rdata` is 0, `rts_n` is 1 and the copied configuration is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; configuration is copied while low |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_one_smp | input | 1 | 1 = single centre sample for data bits |
| cfg_ovr_off | input | 1 | 1 = overrun detection off, overwrite |
| cfg_rts_en | input | 1 | 1 = drive rts_n from buffer room |
| rd_stb | input | 1 | Read strobe, clears rvalid |
| flag_clr | input | 1 | Clears overrun, noise and framing flags |
| rdata | output | 8 | Holding register |
| rvalid | output | 1 | Holding register contains an unread byte |
| ovr_flag | output | 1 | Sticky overrun flag |
| noise_flag | output | 1 | Sticky noise flag |
| frm_flag | output | 1 | Sticky framing-error flag |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
A byte reaches `rdata`, `rvalid` and the flags one clock after the tick at sample 9 of its stop bit. That tick comes two synchronizer clocks after the line level it samples. The bench therefore drives each bit as sixteen slots aligned to the tick grid, so every byte is settled by the end of the stop bit. The reference model is updated there, and the model is not compared against the outputs while a frame is on the line. Read strobes, flag clears and configuration copies take effect at the next clock edge, and `rts_n` follows `rvalid` in the same cycle. These are compared against the model half a clock after every edge.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic one_smp;
        logic ovr_off;
        logic rts_en;
    } rx_cfg_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == CNT_LAST);

    generate
        if (CLK_DIV > 1) begin : g_gap_chk
            p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick on consecutive clocks");
        end
    endgenerate

endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              one_smp,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_noise,
    output logic              done_ferr
);
    localparam int SCW   = $clog2(OVS);
    localparam int IDXW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SCW-1:0]  SMP_A   = SCW'(OVS / 2 - 1);
    localparam logic [SCW-1:0]  SMP_B   = SCW'(OVS / 2);
    localparam logic [SCW-1:0]  SMP_C   = SCW'(OVS / 2 + 1);
    localparam logic [SCW-1:0]  SC_LAST = SCW'(OVS - 1);
    localparam logic [IDXW-1:0] BIT_LAST = IDXW'(DATA_W - 1);

    rx_state_e         state, nxt;
    logic [SCW-1:0]    sc;
    logic [IDXW-1:0]   bidx;
    logic [DATA_W-1:0] shreg;
    logic              smp_a, smp_b;
    logic              noise_acc;

    logic at_c, at_last, maj, disagree, data_bit;

    assign at_c     = tick && (sc == SMP_C);
    assign at_last  = tick && (sc == SC_LAST);
    assign maj      = vote3(smp_a, smp_b, rx_s);
    assign disagree = !((smp_a == smp_b) && (smp_b == rx_s));
    assign data_bit = one_smp ? smp_b : maj;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && !rx_s) nxt = ST_START;              // start_seen
            ST_START: begin
                if (at_c && maj)     nxt = ST_IDLE;                   // false_start
                else if (at_last)    nxt = ST_DATA;                   // start_ok
            end
            ST_DATA:  if (at_last && bidx == BIT_LAST) nxt = ST_STOP; // last_bit
            ST_STOP:  if (at_c) nxt = ST_IDLE;                        // frame_end
        endcase
        if (!en) nxt = ST_IDLE;                                       // disable
    end

    // sample counter, bit index, shifter and noise accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc        <= '0;
            bidx      <= '0;
            shreg     <= '0;
            smp_a     <= 1'b1;
            smp_b     <= 1'b1;
            noise_acc <= 1'b0;
        end else if (!en) begin
            sc        <= '0;
            bidx      <= '0;
            noise_acc <= 1'b0;
        end else if (tick) begin
            if (state == ST_IDLE) begin
                sc        <= SCW'(1);
                bidx      <= '0;
                noise_acc <= 1'b0;
            end else begin
                sc <= (sc == SC_LAST) ? '0 : sc + 1'b1;
                if (sc == SMP_A) smp_a <= rx_s;
                if (sc == SMP_B) smp_b <= rx_s;
                if (sc == SMP_C && disagree && !one_smp) noise_acc <= 1'b1;
                if (state == ST_DATA && sc == SMP_C)
                    shreg <= {data_bit, shreg[DATA_W-1:1]};
                if (state == ST_DATA && sc == SC_LAST)
                    bidx <= bidx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        done       = en && (state == ST_STOP) && at_c;
        done_data  = shreg;
        done_ferr  = !maj;
        done_noise = noise_acc || (disagree && !one_smp);
    end

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("delivery pulse longer than one clock");

    p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && at_c && smp_a && smp_b && rx_s) |=> (state == ST_IDLE))
        else $error("rejected start bit did not return to idle");

    p_single_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && one_smp) |-> !done_noise)
        else $error("noise reported in single-sample mode");

endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] done_data,
    input  logic              done_noise,
    input  logic              done_ferr,
    input  logic              rd_stb,
    input  logic              flag_clr,
    input  logic              ovr_off,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ovr_flag,
    output logic              noise_flag,
    output logic              frm_flag
);
    logic still_full, collide, take;

    assign still_full = rvalid && !rd_stb;
    assign collide    = done && still_full && !ovr_off;
    assign take       = done && !collide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata      <= '0;
            rvalid     <= 1'b0;
            ovr_flag   <= 1'b0;
            noise_flag <= 1'b0;
            frm_flag   <= 1'b0;
        end else begin
            if (take) begin
                rdata  <= done_data;
                rvalid <= 1'b1;
            end else if (rd_stb) begin
                rvalid <= 1'b0;
            end
            ovr_flag   <= (ovr_flag   && !flag_clr) || collide;
            noise_flag <= (noise_flag && !flag_clr) || (done && done_noise);
            frm_flag   <= (frm_flag   && !flag_clr) || (done && done_ferr);
        end
    end

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> !rvalid)
        else $error("read strobe did not empty the register");

    p_ovr_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rvalid && !rd_stb && !ovr_off) |=> (ovr_flag && rvalid && $stable(rdata)))
        else $error("overrun did not keep the older byte");

    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovr_off && !flag_clr) |=> (rvalid && rdata == $past(done_data) && $stable(ovr_flag)))
        else $error("overwrite mode misbehaved");

    p_clear_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !done) |=> (!ovr_flag && !noise_flag && !frm_flag))
        else $error("flag clear ignored");

endmodule

// File: rtl/uart_rx_ovr.sv
module uart_rx_ovr
    import urx_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_i,
    input  logic              cfg_one_smp,
    input  logic              cfg_ovr_off,
    input  logic              cfg_rts_en,
    input  logic              rd_stb,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ovr_flag,
    output logic              noise_flag,
    output logic              frm_flag,
    output logic              rts_n
);
    rx_cfg_t           cfg_l;
    logic              tick, rx_s;
    logic              done, done_noise, done_ferr;
    logic [DATA_W-1:0] done_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_l <= '0;
        end else if (!en) begin
            cfg_l.one_smp <= cfg_one_smp;
            cfg_l.ovr_off <= cfg_ovr_off;
            cfg_l.rts_en  <= cfg_rts_en;
        end
    end

    urx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .tick (tick)
    );

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rx_i),
        .q    (rx_s)
    );

    urx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .rx_s      (rx_s),
        .one_smp   (cfg_l.one_smp),
        .done      (done),
        .done_data (done_data),
        .done_noise(done_noise),
        .done_ferr (done_ferr)
    );

    urx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_data (done_data),
        .done_noise(done_noise),
        .done_ferr (done_ferr),
        .rd_stb    (rd_stb),
        .flag_clr  (flag_clr),
        .ovr_off   (cfg_l.ovr_off),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .ovr_flag  (ovr_flag),
        .noise_flag(noise_flag),
        .frm_flag  (frm_flag)
    );

    assign rts_n = !(cfg_l.rts_en && !rvalid);

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg_l))
        else $error("configuration changed while enabled");

endmodule

// File: tb/sim_uart_rx_ovr.sv
module sim_uart_rx_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rx_i = 1'b1;
    logic       cfg_one_smp = 1'b0, cfg_ovr_off = 1'b0, cfg_rts_en = 1'b0;
    logic       rd_stb = 1'b0, flag_clr = 1'b0;
    logic [7:0] rdata;
    logic       rvalid, ovr_flag, noise_flag, frm_flag, rts_n;

    always #4 clk = ~clk;

    uart_rx_ovr u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_i(rx_i),
        .cfg_one_smp(cfg_one_smp), .cfg_ovr_off(cfg_ovr_off), .cfg_rts_en(cfg_rts_en),
        .rd_stb(rd_stb), .flag_clr(flag_clr),
        .rdata(rdata), .rvalid(rvalid), .ovr_flag(ovr_flag),
        .noise_flag(noise_flag), .frm_flag(frm_flag), .rts_n(rts_n)
    );

    localparam int DIV = 4;
    int total = 0, bad = 0;
    bit busy = 1'b1;
    int ph = 0;

    // reference model state, written only by the stimulus tasks
    logic [7:0] m_data  = 8'h00;
    logic       m_valid = 1'b0, m_ovr = 1'b0, m_noise = 1'b0, m_frm = 1'b0;
    logic       m_one = 1'b0, m_ovroff = 1'b0, m_rtsen = 1'b0;

    always @(posedge clk) begin
        if (!en) ph <= 0;
        else     ph <= ph + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (!busy) begin
            chk("R1 rdata",      rdata,      m_data);
            chk("R5 rvalid",     rvalid,     m_valid);
            chk("R6 ovr_flag",   ovr_flag,   m_ovr);
            chk("R3 noise_flag", noise_flag, m_noise);
            chk("R8 frm_flag",   frm_flag,   m_frm);
            chk("R10 rts_n",     rts_n,      !(m_rtsen && !m_valid));
        end
    end

    task automatic cfg_disabled(input logic one, input logic ovroff, input logic rtsen);
        @(negedge clk);
        en = 1'b0;
        cfg_one_smp = one; cfg_ovr_off = ovroff; cfg_rts_en = rtsen;
        @(negedge clk);
        m_one = one; m_ovroff = ovroff; m_rtsen = rtsen;
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        m_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_ovr = 1'b0; m_noise = 1'b0; m_frm = 1'b0;
    endtask

    task automatic align();
        while (ph % DIV != 1) @(negedge clk);
    endtask

    // gbit: 0 = start, 1..8 = data bits, 9 = stop; gslot: slot to invert
    task automatic send(input logic [7:0] b, input logic stopv,
                        input int gbit, input int gslot,
                        input logic [7:0] exp_b, input logic noisy);
        logic [9:0] fr;
        fr = {stopv, b, 1'b0};
        align();
        busy = 1'b1;
        for (int bi = 0; bi < 10; bi++) begin
            for (int s = 0; s < 16; s++) begin
                rx_i = (bi == gbit && s == gslot) ? ~fr[bi] : fr[bi];
                repeat (DIV) @(negedge clk);
            end
        end
        rx_i = 1'b1;
        if (m_valid && !m_ovroff) m_ovr = 1'b1;
        else begin m_data = exp_b; m_valid = 1'b1; end
        if (noisy && !m_one) m_noise = 1'b1;
        if (!stopv) m_frm = 1'b1;
        busy = 1'b0;
    endtask

    // one bit period with the slots in low_mask held low, then idle
    task automatic false_start(input logic [15:0] low_mask);
        align();
        busy = 1'b1;
        for (int s = 0; s < 16; s++) begin
            rx_i = !low_mask[s];
            repeat (DIV) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (32 * DIV) @(negedge clk);
        busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R12 rvalid", rvalid, 0);
        chk("R12 flags", {ovr_flag, noise_flag, frm_flag}, 0);
        chk("R12 rts_n", rts_n, 1);
        chk("R12 rdata", rdata, 0);
        busy = 1'b0;

        cfg_disabled(1'b0, 1'b0, 1'b1);
        #1 chk("R10 rts low when empty", rts_n, 0);

        send(8'hA5, 1'b1, -1, 0, 8'hA5, 1'b0);
        #1 chk("R1 byte A5", rdata, 8'hA5);
        chk("R1 valid", rvalid, 1);
        chk("R10 rts high when full", rts_n, 1);

        do_read();
        #1 chk("R5 read empties", rvalid, 0);

        send(8'h3C, 1'b1, -1, 0, 8'h3C, 1'b0);
        send(8'hC3, 1'b1, -1, 0, 8'hC3, 1'b0);
        #1 chk("R6 overrun flag", ovr_flag, 1);
        chk("R6 old byte kept", rdata, 8'h3C);

        do_clear();
        #1 chk("R9 clear", {ovr_flag, noise_flag, frm_flag}, 0);
        do_read();

        send(8'h5A, 1'b1, 3, 8, 8'h5A, 1'b1);
        #1 chk("R3 majority data", rdata, 8'h5A);
        chk("R3 noise set", noise_flag, 1);
        do_clear();
        do_read();

        send(8'h81, 1'b0, -1, 0, 8'h81, 1'b0);
        #1 chk("R8 framing flag", frm_flag, 1);
        chk("R8 byte delivered", rdata, 8'h81);
        chk("R8 valid", rvalid, 1);
        do_clear();
        do_read();

        false_start(16'h0001);
        #1 chk("R2 glitch ignored", rvalid, 0);
        false_start(16'h017F);
        #1 chk("R2 minority start ignored", rvalid, 0);

        // changes while enabled must be ignored
        @(negedge clk);
        cfg_one_smp = 1'b1; cfg_ovr_off = 1'b1; cfg_rts_en = 1'b0;
        repeat (8) @(negedge clk);
        #1 chk("R11 rts setting kept", rts_n, 0);
        send(8'h11, 1'b1, -1, 0, 8'h11, 1'b0);
        send(8'h22, 1'b1, -1, 0, 8'h22, 1'b0);
        #1 chk("R11 overrun still on", ovr_flag, 1);
        chk("R11 data kept", rdata, 8'h11);
        do_clear();
        do_read();

        cfg_disabled(1'b1, 1'b1, 1'b0);
        #1 chk("R10 rts off", rts_n, 1);
        send(8'h40, 1'b1, 1, 8, 8'h41, 1'b1);
        #1 chk("R4 centre sample used", rdata, 8'h41);
        chk("R4 no noise", noise_flag, 0);
        send(8'h40, 1'b1, 1, 7, 8'h40, 1'b1);
        #1 chk("R7 overwritten", rdata, 8'h40);
        chk("R7 no overrun", ovr_flag, 0);
        chk("R4 still no noise", noise_flag, 0);

        false_start(16'h017F);
        #1 chk("R2 start voted in single mode", rdata, 8'h40);
        chk("R2 valid unchanged", rvalid, 1);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule